// File: doc/BRIEF.md
# Four-Step Fringe Phase and Modulation Unit

This block is a streaming per-pixel processor for four-sample phase-shift fringe analysis. In each transfer it takes four intensity samples of one pixel, taken at pattern shifts of 0, π/2, π and 3π/2. From these it forms the sine term `S = I3 - I1` and the cosine term `C = I0 - I2`. A vectoring rotation pipeline with one stage per iteration turns the vector (C, S) into the wrapped phase and into its length. The length is corrected by the constant rotation gain to give the fringe modulation `B = sqrt(S² + C²) / 2`. A divider chain then forms the quality ratio `B / A`, where `A` is the mean of the four samples. The pixel is flagged usable when this ratio is strictly greater than a programmable threshold.

Both edges of the block use valid/ready. An input transfer happens on a rising edge where `in_valid` and `in_ready` are both high. An output transfer happens on a rising edge where `out_valid` and `out_ready` are both high. The pipeline moves as a single unit. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every stage holds, `in_ready` is low and the outputs stay frozen. `thr` is a plain control input and should stay constant while pixels are in flight.

Top module: `pmu_phase_unit`

## Requirements
- R1: `in_ready` is high when `out_valid` is low or `out_ready` is high, and low while `out_valid` is high and `out_ready` is low; no input is accepted in that state.
- R2: While `out_valid` is high and `out_ready` is low, all output fields hold their values and `out_valid` stays high on the next cycle.
- R3: With `out_ready` held high, a pixel accepted on edge t is presented on edge t+ITER+RW+2 (24 with defaults). Back-to-back inputs give one result on every clock.
- R4: `out_phase` equals atan2(I3-I1, I0-I2), mapped to [0, 2π) as an unsigned 16-bit code with 65536 codes per turn (0 = 0 rad, 16384 = π/2). The error is at most 12 codes, counted modulo the turn.
- R5: R4 holds in all four quadrants and on all four axes, including vectors whose angle is just below a full turn.
- R6: `out_mod` equals sqrt((I3-I1)² + (I0-I2)²)/2 within ±2.
- R7: When I3 = I1 and I0 = I2, `out_phase` is 0 and `out_mod` is 0.
- R8: Let A = floor((I0+I1+I2+I3)/4). If A > 0, `out_ratio` is an unsigned Q1.RW value (1024 means 1.0 with defaults). It equals floor(`out_mod`·2^RW / A) when `out_mod` < A, and exactly 2^RW otherwise.
- R9: If A > 0, `out_usable` is 1 exactly when `out_ratio` > `thr`. A ratio equal to the threshold is not usable.
- R10: If A = 0, `out_ratio` is 0 and `out_usable` is 0, whatever the modulation.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can accept a pixel this cycle |
| in_i0 | input | DW | Sample at 0 shift |
| in_i1 | input | DW | Sample at π/2 shift |
| in_i2 | input | DW | Sample at π shift |
| in_i3 | input | DW | Sample at 3π/2 shift |
| thr | input | RW+1 | Quality threshold, Q1.RW |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_phase | output | PW | Wrapped phase code, full turn = 2^PW |
| out_mod | output | DW | Modulation B |
| out_ratio | output | RW+1 | B/A quality ratio, Q1.RW, saturated at 1.0 |
| out_usable | output | 1 | Ratio above threshold and A nonzero |

## Verification
The stimulus set has vectors on all four axes, which separate a correct half-turn pre-rotation from a broken one. It has one vector inside each quadrant, which catch sign or direction errors in the rotation stages. Two vectors sit one code either side of zero angle and exercise the wrap to just below a full turn. Further patterns cover equal samples (no modulation), an all-zero pixel and a pixel whose mean floors to zero while its modulation is not zero, a full-scale vector whose ratio saturates, and a low-contrast pixel whose ratio lands below the threshold. A stall with results piling up in the pipeline checks the hold rules, and rerunning one pixel with the threshold set at and just below its ratio pins down the strict compare.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  // Arctangent of 2^-idx, in units where a full turn is 2^32.
  function automatic logic [31:0] atan_turn32(input int idx);
    case (idx)
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10679838;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      default: return 32'd0;
    endcase
  endfunction

  // Same angle rescaled, with rounding, to a turn of 2^aw units.
  function automatic int unsigned atan_step(input int idx, input int aw);
    logic [32:0] t;
    t = {1'b0, atan_turn32(idx)} + (33'd1 << (31 - aw));
    return 32'(t >> (32 - aw));
  endfunction

endpackage

// File: rtl/pmu_prep.sv
module pmu_prep #(
  parameter int DW = 12,
  parameter int XW = 27,
  parameter int FG = 12,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_v,
  input  logic [DW-1:0]        i0,
  input  logic [DW-1:0]        i1,
  input  logic [DW-1:0]        i2,
  input  logic [DW-1:0]        i3,
  output logic                 out_v,
  output logic signed [XW-1:0] out_x,
  output logic signed [XW-1:0] out_y,
  output logic [AW-1:0]        out_z,
  output logic [DW:0]          out_sb
);
  localparam logic [AW-1:0] HALF_TURN = AW'(1) << (AW - 1);

  logic signed [DW:0]   cos_t, sin_t;
  logic signed [XW-1:0] cos_w, sin_w;
  logic [DW+1:0]        sum4;
  logic                 flip;

  always_comb begin
    cos_t = $signed({1'b0, i0}) - $signed({1'b0, i2});
    sin_t = $signed({1'b0, i3}) - $signed({1'b0, i1});
    cos_w = XW'(cos_t) <<< FG;
    sin_w = XW'(sin_t) <<< FG;
    sum4  = {2'b00, i0} + {2'b00, i1} + {2'b00, i2} + {2'b00, i3};
    flip  = cos_t[DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  out_v <= 1'b0;
    else if (en) out_v <= in_v;
  end

  // Left half-plane vectors are turned by a half turn so the
  // rotation chain only ever sees angles within +/- a quarter turn.
  always_ff @(posedge clk) begin
    if (en) begin
      out_x  <= flip ? -cos_w : cos_w;
      out_y  <= flip ? -sin_w : sin_w;
      out_z  <= flip ? HALF_TURN : '0;
      out_sb <= {(cos_t == '0) && (sin_t == '0), DW'(sum4 >> 2)};
    end
  end
endmodule

// File: rtl/pmu_cordic_stage.sv
module pmu_cordic_stage #(
  parameter int          XW    = 27,
  parameter int          AW    = 20,
  parameter int          SBW   = 13,
  parameter int          SHIFT = 0,
  parameter int unsigned ANGLE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_v,
  input  logic signed [XW-1:0] in_x,
  input  logic signed [XW-1:0] in_y,
  input  logic [AW-1:0]        in_z,
  input  logic [SBW-1:0]       in_sb,
  output logic                 out_v,
  output logic signed [XW-1:0] out_x,
  output logic signed [XW-1:0] out_y,
  output logic [AW-1:0]        out_z,
  output logic [SBW-1:0]       out_sb
);
  localparam logic [AW-1:0] STEP = AW'(ANGLE);

  logic signed [XW-1:0] x_sh, y_sh;
  logic                 y_pos;

  always_comb begin
    x_sh  = in_x >>> SHIFT;
    y_sh  = in_y >>> SHIFT;
    y_pos = !in_y[XW-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  out_v <= 1'b0;
    else if (en) out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_x  <= y_pos ? in_x + y_sh : in_x - y_sh;
      out_y  <= y_pos ? in_y - x_sh : in_y + x_sh;
      out_z  <= y_pos ? in_z + STEP : in_z - STEP;
      out_sb <= in_sb;
    end
  end
endmodule

// File: rtl/pmu_div_stage.sv
module pmu_div_stage #(
  parameter int DW  = 12,
  parameter int RW  = 10,
  parameter int SBW = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           in_v,
  input  logic [DW-1:0]  in_rem,
  input  logic [DW-1:0]  in_den,
  input  logic [RW-1:0]  in_q,
  input  logic           in_sat,
  input  logic           in_az,
  input  logic [SBW-1:0] in_sb,
  output logic           out_v,
  output logic [DW-1:0]  out_rem,
  output logic [DW-1:0]  out_den,
  output logic [RW-1:0]  out_q,
  output logic           out_sat,
  output logic           out_az,
  output logic [SBW-1:0] out_sb
);
  logic [DW:0] rem2, rem_nx;
  logic        take;

  always_comb begin
    rem2   = {in_rem, 1'b0};
    take   = rem2 >= {1'b0, in_den};
    rem_nx = take ? rem2 - {1'b0, in_den} : rem2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  out_v <= 1'b0;
    else if (en) out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_rem <= DW'(rem_nx);
      out_den <= in_den;
      out_q   <= RW'({in_q, take});
      out_sat <= in_sat;
      out_az  <= in_az;
      out_sb  <= in_sb;
    end
  end
endmodule

// File: rtl/pmu_phase_unit.sv
module pmu_phase_unit #(
  parameter int DW   = 12,
  parameter int ITER = 12,
  parameter int PW   = 16,
  parameter int RW   = 10,
  parameter int GAIN = 39796
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_i0,
  input  logic [DW-1:0] in_i1,
  input  logic [DW-1:0] in_i2,
  input  logic [DW-1:0] in_i3,
  input  logic [RW:0]   thr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_phase,
  output logic [DW-1:0] out_mod,
  output logic [RW:0]   out_ratio,
  output logic          out_usable
);
  localparam int FG  = ITER;
  localparam int XW  = DW + 3 + FG;
  localparam int ZG  = 4;
  localparam int AW  = PW + ZG;
  localparam int SBC = DW + 1;
  localparam int SBD = PW + DW;
  localparam int GSH = FG + 17;
  localparam int PRW = XW + 17;
  localparam logic [PRW-1:0] G_RND = PRW'(1) << (GSH - 1);
  localparam logic [AW-1:0]  Z_RND = AW'(1) << (ZG - 1);
  localparam logic [RW:0]    ONE_Q = (RW + 1)'(1) << RW;

  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  // Rotation chain
  logic                 cv  [ITER+1];
  logic signed [XW-1:0] cx  [ITER+1];
  logic signed [XW-1:0] cy  [ITER+1];
  logic [AW-1:0]        cz  [ITER+1];
  logic [SBC-1:0]       csb [ITER+1];

  pmu_prep #(.DW(DW), .XW(XW), .FG(FG), .AW(AW)) u_prep (
    .clk(clk), .rst_n(rst_n), .en(en), .in_v(in_valid),
    .i0(in_i0), .i1(in_i1), .i2(in_i2), .i3(in_i3),
    .out_v(cv[0]), .out_x(cx[0]), .out_y(cy[0]), .out_z(cz[0]), .out_sb(csb[0])
  );

  for (genvar k = 0; k < ITER; k++) begin : g_rot
    pmu_cordic_stage #(
      .XW(XW), .AW(AW), .SBW(SBC), .SHIFT(k),
      .ANGLE(pmu_pkg::atan_step(k, AW))
    ) u_stage (
      .clk(clk), .rst_n(rst_n), .en(en),
      .in_v(cv[k]), .in_x(cx[k]), .in_y(cy[k]), .in_z(cz[k]), .in_sb(csb[k]),
      .out_v(cv[k+1]), .out_x(cx[k+1]), .out_y(cy[k+1]), .out_z(cz[k+1]),
      .out_sb(csb[k+1])
    );
  end

  // Gain correction and phase rounding
  logic [PRW-1:0] gprod;
  logic [AW-1:0]  zr;
  logic           g_v;
  logic [PW-1:0]  g_ph;
  logic [DW-1:0]  g_b, g_a;

  always_comb begin
    gprod = PRW'($unsigned(cx[ITER])) * PRW'(GAIN) + G_RND;
    zr    = cz[ITER] + Z_RND;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  g_v <= 1'b0;
    else if (en) g_v <= cv[ITER];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      g_b  <= DW'(gprod >> GSH);
      g_ph <= csb[ITER][DW] ? '0 : PW'(zr >> ZG);
      g_a  <= csb[ITER][DW-1:0];
    end
  end

  // Ratio divider, one quotient bit per stage
  logic           dv   [RW+1];
  logic [DW-1:0]  drem [RW+1];
  logic [DW-1:0]  dden [RW+1];
  logic [RW-1:0]  dq   [RW+1];
  logic           dsat [RW+1];
  logic           daz  [RW+1];
  logic [SBD-1:0] dsb  [RW+1];

  assign dv[0]   = g_v;
  assign dsat[0] = g_b >= g_a;
  assign drem[0] = (g_b >= g_a) ? '0 : g_b;
  assign dden[0] = g_a;
  assign dq[0]   = '0;
  assign daz[0]  = g_a == '0;
  assign dsb[0]  = {g_ph, g_b};

  for (genvar k = 0; k < RW; k++) begin : g_div
    pmu_div_stage #(.DW(DW), .RW(RW), .SBW(SBD)) u_stage (
      .clk(clk), .rst_n(rst_n), .en(en),
      .in_v(dv[k]), .in_rem(drem[k]), .in_den(dden[k]), .in_q(dq[k]),
      .in_sat(dsat[k]), .in_az(daz[k]), .in_sb(dsb[k]),
      .out_v(dv[k+1]), .out_rem(drem[k+1]), .out_den(dden[k+1]), .out_q(dq[k+1]),
      .out_sat(dsat[k+1]), .out_az(daz[k+1]), .out_sb(dsb[k+1])
    );
  end

  // Output register
  logic [RW:0] q_fin;
  always_comb begin
    if (daz[RW])       q_fin = '0;
    else if (dsat[RW]) q_fin = ONE_Q;
    else               q_fin = {1'b0, dq[RW]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  out_valid <= 1'b0;
    else if (en) out_valid <= dv[RW];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_phase  <= dsb[RW][SBD-1:DW];
      out_mod    <= dsb[RW][DW-1:0];
      out_ratio  <= q_fin;
      out_usable <= !daz[RW] && (q_fin > thr);
    end
  end
endmodule

// File: rtl/pmu_phase_unit_chk.sv
module pmu_phase_unit_chk #(
  parameter int DW = 12,
  parameter int PW = 16,
  parameter int RW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic [RW:0]   thr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_phase,
  input logic [DW-1:0] out_mod,
  input logic [RW:0]   out_ratio,
  input logic          out_usable
);
  localparam logic [RW:0] ONE_Q = (RW + 1)'(1) << RW;

  a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && in_ready));

  a_r1_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r1_empty_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_phase) && $stable(out_mod)
                                   && $stable(out_ratio) && $stable(out_usable)));

  a_r8_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ratio <= ONE_Q));

  a_r9_usable_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_usable) |-> (out_ratio > thr));

  a_r10_zero_ratio_unusable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ratio == '0) |-> !out_usable);
endmodule

bind pmu_phase_unit pmu_phase_unit_chk #(.DW(DW), .PW(PW), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .thr(thr),
  .out_valid(out_valid), .out_ready(out_ready), .out_phase(out_phase),
  .out_mod(out_mod), .out_ratio(out_ratio), .out_usable(out_usable)
);

// File: tb/pmu_phase_unit_tb_top.sv
`timescale 1ns/1ps
module pmu_phase_unit_tb_top;
  localparam int DW = 12, PW = 16, RW = 10, ITER = 12;
  localparam int LAT = ITER + RW + 2;
  localparam int NV = 17;
  localparam real TWO_PI = 6.283185307179586;

  // {i0, i1, i2, i3}
  localparam logic [47:0] VEC [NV] = '{
    {12'd300,  12'd200,  12'd100,  12'd200},   // +C axis
    {12'd200,  12'd100,  12'd200,  12'd300},   // +S axis
    {12'd100,  12'd200,  12'd300,  12'd200},   // -C axis
    {12'd200,  12'd300,  12'd200,  12'd100},   // -S axis
    {12'd1000, 12'd500,  12'd200,  12'd900},   // Q1
    {12'd200,  12'd400,  12'd900,  12'd1500},  // Q2
    {12'd100,  12'd1200, 12'd600,  12'd300},   // Q3
    {12'd3000, 12'd2500, 12'd400,  12'd700},   // Q4
    {12'd500,  12'd500,  12'd500,  12'd500},   // no modulation
    {12'd0,    12'd0,    12'd0,    12'd0},     // all zero
    {12'd4095, 12'd0,    12'd0,    12'd4095},  // full scale, saturating ratio
    {12'd3,    12'd0,    12'd0,    12'd0},     // mean floors to zero
    {12'd2048, 12'd2100, 12'd2052, 12'd2000},  // low contrast
    {12'd0,    12'd4095, 12'd4095, 12'd0},     // Q3 full scale
    {12'd10,   12'd0,    12'd0,    12'd20},    // small vector
    {12'd2000, 12'd1000, 12'd0,    12'd1001},  // just above zero angle
    {12'd2000, 12'd1001, 12'd0,    12'd1000}   // just below full turn
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_i0 = '0, in_i1 = '0, in_i2 = '0, in_i3 = '0;
  logic [RW:0]   thr = 11'd205;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_phase;
  logic [DW-1:0] out_mod;
  logic [RW:0]   out_ratio;
  logic          out_usable;

  always #2 clk = ~clk;

  pmu_phase_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i0(in_i0), .in_i1(in_i1), .in_i2(in_i2), .in_i3(in_i3), .thr(thr),
    .out_valid(out_valid), .out_ready(out_ready), .out_phase(out_phase),
    .out_mod(out_mod), .out_ratio(out_ratio), .out_usable(out_usable)
  );

  int n_chk = 0, n_fail = 0;
  int wr = 0, rd = 0, cyc = 0;
  logic [47:0] sent [256];
  int          out_cyc [256];
  int          last_ratio = 0;
  logic        last_usable = 1'b0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && in_valid && in_ready) begin
      sent[wr[7:0]] <= {in_i0, in_i1, in_i2, in_i3};
      wr <= wr + 1;
    end
  end

  // Result checker: expected values from the requirements
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [47:0] v;
      int a0, a1, a2, a3, sv, cv, am, rexp, pexp, d, bo;
      real ph, bm;
      bit zero, uexp;
      string ptag;
      v  = sent[rd[7:0]];
      a0 = int'(v[47:36]); a1 = int'(v[35:24]); a2 = int'(v[23:12]); a3 = int'(v[11:0]);
      cv = a0 - a2; sv = a3 - a1;
      am = (a0 + a1 + a2 + a3) / 4;
      zero = (cv == 0) && (sv == 0);
      bo = int'(out_mod);
      // R4 / R5 / R7 phase
      if (zero) begin
        check(out_phase == 0, "R7", "phase", int'(out_phase), 0);
        check(out_mod == 0, "R7", "modulation", bo, 0);
      end else begin
        ph = $atan2(real'(sv), real'(cv));
        if (ph < 0.0) ph = ph + TWO_PI;
        pexp = int'(ph / TWO_PI * 65536.0) % 65536;
        d = int'(out_phase) - pexp;
        if (d > 32767) d = d - 65536;
        if (d < -32768) d = d + 65536;
        ptag = (cv <= 0 || sv <= 0) ? "R5" : "R4";
        check(d <= 12 && d >= -12, ptag, "phase", int'(out_phase), pexp);
        bm = 0.5 * $sqrt(real'(sv * sv + cv * cv));
        check((real'(bo) - bm) <= 2.0 && (bm - real'(bo)) <= 2.0, "R6", "modulation",
              bo, int'(bm));
      end
      // R8 / R10 ratio, R9 / R10 usable
      if (am == 0) begin
        check(out_ratio == 0, "R10", "ratio", int'(out_ratio), 0);
        check(out_usable == 0, "R10", "usable", int'(out_usable), 0);
      end else begin
        rexp = (bo >= am) ? (1 << RW) : (bo * (1 << RW)) / am;
        uexp = rexp > int'(thr);
        check(int'(out_ratio) == rexp, "R8", "ratio", int'(out_ratio), rexp);
        check(out_usable == uexp, "R9", "usable", int'(out_usable), int'(uexp));
      end
      last_ratio  = int'(out_ratio);
      last_usable = out_usable;
      out_cyc[rd[7:0]] = cyc;
      rd++;
    end
  end

  task automatic push(input logic [47:0] v);
    {in_i0, in_i1, in_i2, in_i3} = v;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (rd != wr) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, r0, hold_ph, hold_mod, hold_rat, r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(out_valid == 0, "R11", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1, "R11", "in_ready after reset", int'(in_ready), 1);

    // R3 latency, single pixel into an empty pipeline
    {in_i0, in_i1, in_i2, in_i3} = VEC[0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == LAT, "R3", "latency edges", n, LAT);
    drain();

    // Vector table, back to back
    r0 = rd;
    for (int k = 0; k < NV; k++) push(VEC[k]);
    drain();
    check(out_cyc[(r0 + NV - 1) % 256] - out_cyc[r0 % 256] == NV - 1, "R3",
          "throughput span", out_cyc[(r0 + NV - 1) % 256] - out_cyc[r0 % 256], NV - 1);

    // R1 / R2 back-pressure
    out_ready = 1'b0;
    push(VEC[4]);
    push(VEC[5]);
    while (!out_valid) @(negedge clk);
    check(in_ready == 0, "R1", "in_ready during stall", int'(in_ready), 0);
    hold_ph = int'(out_phase); hold_mod = int'(out_mod); hold_rat = int'(out_ratio);
    repeat (5) @(negedge clk);
    check(out_valid == 1, "R2", "valid held", int'(out_valid), 1);
    check(int'(out_phase) == hold_ph, "R2", "phase held", int'(out_phase), hold_ph);
    check(int'(out_mod) == hold_mod, "R2", "modulation held", int'(out_mod), hold_mod);
    check(int'(out_ratio) == hold_rat, "R2", "ratio held", int'(out_ratio), hold_rat);
    check(in_ready == 0, "R1", "in_ready still low", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    check(in_ready == 1, "R1", "in_ready on drain", int'(in_ready), 1);
    drain();

    // R9 strict threshold compare
    push(VEC[0]);
    drain();
    r = last_ratio;
    thr = (RW + 1)'(r);
    push(VEC[0]);
    drain();
    check(last_usable == 0, "R9", "usable at ratio == thr", int'(last_usable), 0);
    thr = (RW + 1)'(r - 1);
    push(VEC[0]);
    drain();
    check(last_usable == 1, "R9", "usable at ratio == thr+1", int'(last_usable), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule